// File: doc/BRIEF.md
# General-Purpose I/O Port with Write-Only Direction Register

This block is an 8-bit general-purpose I/O port that sits behind a simple register interface. Pin directions are set through a direction register that software can write but cannot read back. The companion port register, at the next address, reports the pin data in its low byte and the direction status in its high byte. The direction status is shown inverted: a 1 there means input.

A write to the direction register is accepted only while a separate unlock bit is set. The host's control register drives that bit into the port. A second bit, from the clock-control register, makes the two top pins available. While that bit is low, those two pins cannot drive and read back as zero.

The pad tristate buffers are modelled as an output-enable vector and an output-data vector. Input levels pass through a two-flop synchronizer before they are readable.

Top module: `gp_port`

## Requirements
- R1: After reset every direction bit is 0, so no pin is enabled as an output and the output latch is 0. Reading the port register then returns 1 in each high-byte bit of an available pin.
- R2: A write to address 0x17 while `dirUnlock` is 1 loads `busWdata[7:0]` into the direction register at the next clock edge. A direction bit of 1 makes its pin an output (`pinOe` bit 1), and the port register's high-byte bit i reads as the inverse of direction bit i.
- R3: A write to address 0x17 while `dirUnlock` is 0 is ignored. `pinOe` and the direction status in the port register keep their previous values.
- R4: A read of address 0x17, or of any address other than 0x18, returns 0. The direction register cannot be read directly.
- R5: A write to address 0x18 loads `busWdata[7:0]` into the output latch at the next clock edge. `pinOut` bit i equals latch bit i for an enabled output pin and is 0 otherwise.
- R6: A change on an input pin appears in the port register's low byte two clock edges after it is sampled, not one.
- R7: In the port register's low byte, bit i shows the latch bit when pin i is an output and the synchronized pin level when pin i is an input.
- R8: While `upperPinsEn` is 0, pins 6 and 7 have output enable and output data forced to 0. Both their low-byte and high-byte bits read 0. Their direction bits are kept and return once `upperPinsEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 8 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, combinational |
| dirUnlock | input | 1 | Control-register bit that permits direction writes |
| upperPinsEn | input | 1 | Clock-control bit that makes pins 6 and 7 available |
| pinIn | input | 8 | Pad input levels, asynchronous |
| pinOe | output | 8 | Pad output enables |
| pinOut | output | 8 | Pad output data |

## Verification
The assertions assume that `busAddr`, `busWe`, `dirUnlock` and `upperPinsEn` are known and held steady around each rising edge once reset is released. They make no assumption about `pinIn`, which may toggle at any time.

The bench changes every input only on the falling edge, so each write, unlock change and gating change is settled before the edge that samples it. Reads are sampled shortly after the address is set. Input pins are changed on the falling edge and then read after one edge and after two, which shows the synchronizer latency.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;
  // strobes from the decoder to the datapath
  typedef struct packed {
    logic dirWr;   // accepted direction write
    logic dataWr;  // output-latch write
    logic portSel; // port register addressed
  } gp_strobe_t;
endpackage

// File: rtl/gp_port_ctrl.sv
module gp_port_ctrl
  import gp_port_pkg::*;
#(
  parameter int AW        = 8,
  parameter int W         = 8,
  parameter int G         = 2,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h17,
  parameter logic [AW-1:0] PORT_ADDR = 8'h18
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          dirUnlock,
  input  logic          upperPinsEn,
  output gp_strobe_t    stb,
  output logic [W-1:0]  availMask
);
  logic dirHit, portHit;

  always_comb begin
    dirHit      = (busAddr == DIR_ADDR);
    portHit     = (busAddr == PORT_ADDR);
    stb.dirWr   = busWe && dirHit && dirUnlock;
    stb.dataWr  = busWe && portHit;
    stb.portSel = portHit;
  end

  // the top G pins depend on the clock-control bit
  for (genvar i = 0; i < W; i++) begin : g_avail
    if (i >= W - G) begin : g_gated
      assign availMask[i] = upperPinsEn;
    end else begin : g_fixed
      assign availMask[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gp_port_dp.sv
module gp_port_dp
  import gp_port_pkg::*;
#(
  parameter int W = 8,
  parameter int G = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  gp_strobe_t   stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] availMask,
  input  logic         upperPinsEn,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinOe,
  output logic [W-1:0] pinOut,
  output logic [2*W-1:0] portRd
);
  logic [W-1:0] dirReg, dataLatch, syncA, syncB, levelView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg    <= '0;
      dataLatch <= '0;
      syncA     <= '0;
      syncB     <= '0;
    end else begin
      if (stb.dirWr)  dirReg    <= wdata;
      if (stb.dataWr) dataLatch <= wdata;
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    pinOe     = dirReg & availMask;
    pinOut    = dataLatch & pinOe;
    levelView = (dirReg & dataLatch) | (~dirReg & syncB);
    portRd    = {~dirReg & availMask, levelView & availMask};
  end

  // R5
  no_stray_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  // R8
  gated_pins_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !upperPinsEn |-> (pinOe[W-1 -: G] == '0 && portRd[2*W-1 -: G] == '0
                      && portRd[W-1 -: G] == '0));
endmodule

// File: rtl/gp_port.sv
module gp_port
  import gp_port_pkg::*;
#(
  parameter int AW = 8,
  parameter int W  = 8,
  parameter int G  = 2,
  parameter logic [AW-1:0] DIR_ADDR  = 8'h17,
  parameter logic [AW-1:0] PORT_ADDR = 8'h18
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWe,
  input  logic [W-1:0]    busWdata,
  output logic [2*W-1:0]  busRdata,
  input  logic            dirUnlock,
  input  logic            upperPinsEn,
  input  logic [W-1:0]    pinIn,
  output logic [W-1:0]    pinOe,
  output logic [W-1:0]    pinOut
);
  localparam int RW = 2 * W;
  localparam int LOW = W - G;

  gp_strobe_t    stb;
  logic [W-1:0]  availMask;
  logic [RW-1:0] portRd;

  gp_port_ctrl #(.AW(AW), .W(W), .G(G), .DIR_ADDR(DIR_ADDR), .PORT_ADDR(PORT_ADDR)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .dirUnlock(dirUnlock),
    .upperPinsEn(upperPinsEn), .stb(stb), .availMask(availMask)
  );

  gp_port_dp #(.W(W), .G(G)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .availMask(availMask),
    .upperPinsEn(upperPinsEn), .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut),
    .portRd(portRd)
  );

  assign busRdata = stb.portSel ? portRd : '0;

  // R2
  dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DIR_ADDR && dirUnlock) |=> pinOe[LOW-1:0] == $past(busWdata[LOW-1:0]));

  // R3
  locked_dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == DIR_ADDR && !dirUnlock && upperPinsEn)
      |=> (!upperPinsEn || $stable(pinOe)));

  // R4
  dir_unreadable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == DIR_ADDR) |-> busRdata == '0);
endmodule

// File: tb/gp_port_bench.sv
module gp_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [15:0] busRdata;
  logic        dirUnlock = 1'b0;
  logic        upperPinsEn = 1'b1;
  logic [7:0]  pinIn = 8'h00;
  logic [7:0]  pinOe, pinOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gp_port u_gp_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .dirUnlock(dirUnlock), .upperPinsEn(upperPinsEn),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  initial begin
    logic [15:0] rd;
    logic [7:0]  lat;
    logic [7:0]  inLvl;
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", {8'h0, pinOe}, 16'h0000);
    check("R1 pinOut", {8'h0, pinOut}, 16'h0000);
    busRead(8'h18, rd);
    check("R1 port read", rd, 16'hFF00);

    // R4 direction register not readable
    dirUnlock = 1'b1;
    @(negedge clk);
    busWrite(8'h17, 8'hA5);
    busRead(8'h17, rd);
    check("R4 read 0x17", rd, 16'h0000);
    busRead(8'h33, rd);
    check("R4 read other", rd, 16'h0000);

    // R2 R5 R7 sweep all direction patterns with a fixed pad level
    inLvl = 8'h5A;
    pinIn = inLvl;
    for (int d = 0; d < 256; d++) begin
      lat = 8'(d) ^ 8'h3C;
      busWrite(8'h17, 8'(d));
      busWrite(8'h18, lat);
      check("R2 pinOe", {8'h0, pinOe}, {8'h0, 8'(d)});
      check("R5 pinOut", {8'h0, pinOut}, {8'h0, lat & 8'(d)});
      busRead(8'h18, rd);
      check("R7 port read", rd, {~8'(d), (8'(d) & lat) | (~8'(d) & inLvl)});
    end

    // R3 locked write ignored
    busWrite(8'h17, 8'hFF);
    dirUnlock = 1'b0;
    busWrite(8'h17, 8'h00);
    check("R3 pinOe kept", {8'h0, pinOe}, 16'h00FF);
    busRead(8'h18, rd);
    check("R3 status kept", rd[15:8], 8'h00);
    dirUnlock = 1'b1;

    // R6 synchronizer latency
    busWrite(8'h17, 8'h00);
    pinIn = 8'h00;
    repeat (3) @(negedge clk);
    pinIn = 8'hC3;
    @(negedge clk);
    busRead(8'h18, rd);
    check("R6 one edge", {8'h0, rd[7:0]}, 16'h0000);
    @(negedge clk);
    busRead(8'h18, rd);
    check("R6 two edges", {8'h0, rd[7:0]}, 16'h00C3);

    // R8 upper pins gated
    busWrite(8'h17, 8'hFF);
    busWrite(8'h18, 8'hFF);
    upperPinsEn = 1'b0;
    #1;
    check("R8 pinOe", {8'h0, pinOe}, 16'h003F);
    check("R8 pinOut", {8'h0, pinOut}, 16'h003F);
    busRead(8'h18, rd);
    check("R8 read outputs", rd, 16'h003F);
    @(negedge clk);
    busWrite(8'h17, 8'h00);
    busRead(8'h18, rd);
    check("R8 read inputs", rd, 16'h3F03);
    busWrite(8'h17, 8'hC0);
    upperPinsEn = 1'b1;
    #1;
    check("R8 restored", {8'h0, pinOe}, 16'h00C0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule